// File: doc/BRIEF.md
# Decoded Micro-Op Trace Cache

This block keeps already-translated instructions close to the fetch stage. A fetch address is presented on a lookup stream. If the entry at that address is present, the block returns a bundle of up to three fixed-format micro-ops. With them come a micro-op count, the number of instructions the bundle covers and the byte distance the fetch address must move. The front end can therefore advance past one to three instructions with a single access.

When the address is not present, the block raises a miss request towards an external instruction decoder. It then waits on a fill port for the translation, writes it into the array and replays the lookup, which now hits. Some translations are too long to be stored; their entries are marked complex. A hit on such an entry starts the micro-ROM sequencer with an entry point taken from the first micro-op slot. The block then holds off all further lookups until the sequencer reports completion, and only then delivers the response.

All three data paths use valid/ready. A lookup is taken on a cycle where `lk_valid` and `lk_ready` are both high. A response stays on the port, unchanged, until `rsp_ready` is seen high. The miss request stays up with a constant address until `miss_ready` is high. A fill is taken on a cycle where `fill_valid` and `fill_ready` are both high. Only one lookup is in flight at a time, so `lk_ready` is low from acceptance until the response is consumed.

Top module: `uop_trace_cache`

## Requirements
- R1: After reset every entry is invalid, `lk_ready` is high, and `rsp_valid`, `miss_valid`, `fill_ready` and `rom_start` are low. The first lookup of any address then misses.
- R2: A lookup is accepted on a rising edge where `lk_valid` and `lk_ready` are both high. `lk_ready` is high only when no lookup is in flight.
- R3: A hit on a non-complex entry raises `rsp_valid` on the second rising edge after acceptance. The response carries the stored micro-ops (slot 0 in bits [31:0], slot 1 in [63:32], slot 2 in [95:64]), the micro-op count (1 to 3), the instruction count (1 to 3), the byte advance and `rsp_complex`=0.
- R4: While `rsp_valid` is high and `rsp_ready` is low, the response and all its fields hold unchanged. The lookup completes on the edge where both are high, and `lk_ready` returns on the following cycle.
- R5: A miss raises `miss_valid`, with `miss_addr` equal to the looked-up address, on the second rising edge after acceptance. Both hold unchanged until `miss_ready` is high.
- R6: After the miss handshake `fill_ready` is high until a fill is taken. The taken fill is written to the entry selected by the address's low 6 bits, and the response for that fill is delivered on the second rising edge after the fill.
- R7: A later lookup of a filled address hits without raising `miss_valid`.
- R8: A hit on an entry filled with `fill_complex`=1 pulses `rom_start` for one cycle on the second rising edge after acceptance, with `rom_entry` equal to micro-op slot 0 bits [11:0]. `rom_done` is ignored in that first cycle. The response, with `rsp_complex`=1, comes on the edge after `rom_done` is seen.
- R9: `lk_ready` stays low while a miss is pending, while a fill is awaited, while the micro-ROM is active and while a response waits.
- R10: The array is direct-mapped with 64 entries and a per-entry tag compare. A fill to an occupied index overwrites it, so the address previously held there misses on its next lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| lk_valid | input | 1 | Lookup request valid |
| lk_ready | output | 1 | Lookup request accepted when high |
| lk_addr | input | 32 | Fetch address to look up |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_uops | output | 96 | Three micro-op slots, slot 0 lowest |
| rsp_uop_cnt | output | 2 | Number of valid micro-op slots |
| rsp_insn_cnt | output | 2 | Instructions covered by the bundle |
| rsp_len | output | 6 | Bytes to add to the fetch address |
| rsp_complex | output | 1 | Entry was executed by the micro-ROM |
| miss_valid | output | 1 | Decode request valid |
| miss_ready | input | 1 | Decoder takes the request |
| miss_addr | output | 32 | Address to decode |
| fill_valid | input | 1 | Fill data valid |
| fill_ready | output | 1 | Block waits for a fill |
| fill_uops | input | 96 | Translated micro-op slots |
| fill_uop_cnt | input | 2 | Micro-op count of the fill |
| fill_insn_cnt | input | 2 | Instruction count of the fill |
| fill_len | input | 6 | Byte advance of the fill |
| fill_complex | input | 1 | Translation too long; run from micro-ROM |
| rom_start | output | 1 | One-cycle start pulse to the micro-ROM sequencer |
| rom_entry | output | 12 | Micro-ROM entry point |
| rom_done | input | 1 | Micro-ROM sequence finished |

## Verification
Every result has a fixed distance from its cause. The response or miss request is due on the second edge after an accepted lookup, and a replayed response on the second edge after a taken fill. The ROM start pulse comes on the second edge after acceptance, and the complex response on the edge after `rom_done`. The bench drives inputs on falling edges and samples at every falling edge between cause and due result. It therefore checks both that an output is still quiet one cycle early and that it is present exactly when due. Back-pressure cases hold `rsp_ready` or `miss_ready` low for several cycles and compare the held values cycle by cycle.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_RESP,
    ST_MISS,
    ST_FILL,
    ST_ROM
  } tc_state_e;
endpackage

// File: rtl/tc_store.sv
module tc_store #(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 26,
  parameter int DATA_W = 107
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 2 ** IDX_W;

  logic [DEPTH-1:0]  vld_q;
  logic [TAG_W-1:0]  tag_q  [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else if (wr_en) vld_q[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx]  <= wr_tag;
      data_q[wr_idx] <= wr_data;
    end
  end

  assign rd_valid = vld_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_data  = data_q[rd_idx];
endmodule

// File: rtl/tc_tag_cmp.sv
module tc_tag_cmp #(
  parameter int TAG_W = 26
) (
  input  logic             ent_valid,
  input  logic [TAG_W-1:0] ent_tag,
  input  logic [TAG_W-1:0] req_tag,
  output logic             hit
);
  assign hit = ent_valid && (ent_tag == req_tag);
endmodule

// File: rtl/tc_ctrl.sv
module tc_ctrl
  import tc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      lk_fire,
  input  logic      hit,
  input  logic      ent_complex,
  input  logic      rsp_ready,
  input  logic      miss_ready,
  input  logic      fill_valid,
  input  logic      rom_done,
  output tc_state_e state,
  output logic      rom_go
);
  tc_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:  if (lk_fire) nxt = ST_CHECK;
      ST_CHECK: nxt = hit ? (ent_complex ? ST_ROM : ST_RESP) : ST_MISS;
      ST_RESP:  if (rsp_ready) nxt = ST_IDLE;
      ST_MISS:  if (miss_ready) nxt = ST_FILL;
      ST_FILL:  if (fill_valid) nxt = ST_CHECK;
      ST_ROM:   if (!rom_go && rom_done) nxt = ST_RESP;
      default:  nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      rom_go <= 1'b0;
    end else begin
      state  <= nxt;
      rom_go <= (state == ST_CHECK) && (nxt == ST_ROM);
    end
  end
endmodule

// File: rtl/uop_trace_cache.sv
module uop_trace_cache
  import tc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int IDX_W    = 6,
  parameter int UOP_W    = 32,
  parameter int MAX_UOPS = 3,
  parameter int LEN_W    = 6,
  parameter int ROM_W    = 12,
  localparam int CNT_W   = $clog2(MAX_UOPS + 1),
  localparam int UOPS_W  = MAX_UOPS * UOP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [UOPS_W-1:0] rsp_uops,
  output logic [CNT_W-1:0]  rsp_uop_cnt,
  output logic [CNT_W-1:0]  rsp_insn_cnt,
  output logic [LEN_W-1:0]  rsp_len,
  output logic              rsp_complex,
  output logic              miss_valid,
  input  logic              miss_ready,
  output logic [ADDR_W-1:0] miss_addr,
  input  logic              fill_valid,
  output logic              fill_ready,
  input  logic [UOPS_W-1:0] fill_uops,
  input  logic [CNT_W-1:0]  fill_uop_cnt,
  input  logic [CNT_W-1:0]  fill_insn_cnt,
  input  logic [LEN_W-1:0]  fill_len,
  input  logic              fill_complex,
  output logic              rom_start,
  output logic [ROM_W-1:0]  rom_entry,
  input  logic              rom_done
);
  localparam int TAG_W  = ADDR_W - IDX_W;
  localparam int DATA_W = 1 + LEN_W + 2 * CNT_W + UOPS_W;

  tc_state_e         state;
  logic              rom_go;
  logic [ADDR_W-1:0] req_addr_q;
  logic              lk_fire, wr_en, hit, ent_valid;
  logic [TAG_W-1:0]  ent_tag;
  logic [DATA_W-1:0] ent_data, wr_data;

  assign lk_ready = (state == ST_IDLE);
  assign lk_fire  = lk_valid && lk_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_addr_q <= '0;
    else if (lk_fire) req_addr_q <= lk_addr;
  end

  assign fill_ready = (state == ST_FILL);
  assign wr_en      = fill_ready && fill_valid;
  assign wr_data    = {fill_complex, fill_len, fill_insn_cnt, fill_uop_cnt, fill_uops};

  tc_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_idx   (req_addr_q[IDX_W-1:0]),
    .wr_tag   (req_addr_q[ADDR_W-1:IDX_W]),
    .wr_data  (wr_data),
    .rd_idx   (req_addr_q[IDX_W-1:0]),
    .rd_valid (ent_valid),
    .rd_tag   (ent_tag),
    .rd_data  (ent_data)
  );

  tc_tag_cmp #(.TAG_W(TAG_W)) u_cmp (
    .ent_valid (ent_valid),
    .ent_tag   (ent_tag),
    .req_tag   (req_addr_q[ADDR_W-1:IDX_W]),
    .hit       (hit)
  );

  assign {rsp_complex, rsp_len, rsp_insn_cnt, rsp_uop_cnt, rsp_uops} = ent_data;

  tc_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .lk_fire     (lk_fire),
    .hit         (hit),
    .ent_complex (rsp_complex),
    .rsp_ready   (rsp_ready),
    .miss_ready  (miss_ready),
    .fill_valid  (fill_valid),
    .rom_done    (rom_done),
    .state       (state),
    .rom_go      (rom_go)
  );

  assign rsp_valid  = (state == ST_RESP);
  assign miss_valid = (state == ST_MISS);
  assign miss_addr  = req_addr_q;
  assign rom_start  = rom_go;
  assign rom_entry  = ent_data[ROM_W-1:0];
endmodule

// File: rtl/tc_chk.sv
module tc_chk #(
  parameter int ADDR_W = 32,
  parameter int UOPS_W = 96,
  parameter int LEN_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lk_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [UOPS_W-1:0] rsp_uops,
  input logic [LEN_W-1:0]  rsp_len,
  input logic              miss_valid,
  input logic              miss_ready,
  input logic [ADDR_W-1:0] miss_addr,
  input logic              fill_ready,
  input logic              rom_start
);
  // R2
  one_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({lk_ready, rsp_valid, miss_valid, fill_ready}));

  // R4
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_uops) && $stable(rsp_len));

  // R5
  miss_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && !miss_ready |=> miss_valid && $stable(miss_addr));

  // R8
  rom_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_start |=> !rom_start && !rsp_valid);

  // R9
  busy_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_start || miss_valid || fill_ready) |-> !lk_ready);

  // R6
  fill_follows_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid && miss_ready |=> fill_ready);
endmodule

bind uop_trace_cache tc_chk #(.ADDR_W(ADDR_W), .UOPS_W(UOPS_W), .LEN_W(LEN_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .lk_ready   (lk_ready),
  .rsp_valid  (rsp_valid),
  .rsp_ready  (rsp_ready),
  .rsp_uops   (rsp_uops),
  .rsp_len    (rsp_len),
  .miss_valid (miss_valid),
  .miss_ready (miss_ready),
  .miss_addr  (miss_addr),
  .fill_ready (fill_ready),
  .rom_start  (rom_start)
);

// File: tb/uop_trace_cache_tb.sv
`timescale 1ns/1ps
module uop_trace_cache_tb;
  logic        clk = 0, rst_n = 0;
  logic        lk_valid = 0, lk_ready;
  logic [31:0] lk_addr = 0;
  logic        rsp_valid, rsp_ready = 0, rsp_complex;
  logic [95:0] rsp_uops;
  logic [1:0]  rsp_uop_cnt, rsp_insn_cnt;
  logic [5:0]  rsp_len;
  logic        miss_valid, miss_ready = 0;
  logic [31:0] miss_addr;
  logic        fill_valid = 0, fill_ready, fill_complex = 0;
  logic [95:0] fill_uops = 0;
  logic [1:0]  fill_uop_cnt = 0, fill_insn_cnt = 0;
  logic [5:0]  fill_len = 0;
  logic        rom_start, rom_done = 0;
  logic [11:0] rom_entry;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  uop_trace_cache u_dut (
    .clk(clk), .rst_n(rst_n), .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_addr(lk_addr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_uops(rsp_uops),
    .rsp_uop_cnt(rsp_uop_cnt), .rsp_insn_cnt(rsp_insn_cnt), .rsp_len(rsp_len),
    .rsp_complex(rsp_complex), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_addr(miss_addr), .fill_valid(fill_valid), .fill_ready(fill_ready),
    .fill_uops(fill_uops), .fill_uop_cnt(fill_uop_cnt), .fill_insn_cnt(fill_insn_cnt),
    .fill_len(fill_len), .fill_complex(fill_complex), .rom_start(rom_start),
    .rom_entry(rom_entry), .rom_done(rom_done)
  );

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [95:0] uops_of(input logic [31:0] a);
    return {a ^ 32'h0000_0A03, a ^ 32'h0000_0B02, a ^ 32'h0000_0C01};
  endfunction

  // entry contents expected for each address
  function automatic logic [1:0] ucnt_of(input logic [31:0] a);
    return 2'(a[3:2] % 3 + 1);
  endfunction
  function automatic logic [1:0] icnt_of(input logic [31:0] a);
    return 2'(a[5:4] % 3 + 1);
  endfunction
  function automatic logic [5:0] len_of(input logic [31:0] a);
    return 6'(a[7:0] % 40 + 1);
  endfunction

  // Offer a lookup; the accept edge lies between the two falling edges.
  task automatic issue(input logic [31:0] a);
    @(negedge clk);
    chk("R2 lk_ready before lookup", lk_ready, 1);
    lk_valid = 1; lk_addr = a;
    @(negedge clk);
    lk_valid = 0;
    chk("R3 nothing due one cycle after accept", {rsp_valid, miss_valid, rom_start}, 0);
  endtask

  task automatic take_rsp(input logic [31:0] a, input bit cplx);
    chk("R3 rsp_valid", rsp_valid, 1);
    chk("R3 rsp_uops", rsp_uops, uops_of(a));
    chk("R3 rsp_uop_cnt", rsp_uop_cnt, ucnt_of(a));
    chk("R3 rsp_insn_cnt", rsp_insn_cnt, icnt_of(a));
    chk("R3 rsp_len", rsp_len, len_of(a));
    chk("R8 rsp_complex", rsp_complex, cplx);
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
    chk("R4 lk_ready back after consume", {lk_ready, rsp_valid}, 2'b10);
  endtask

  task automatic serve_rom(input logic [31:0] a);
    chk("R8 rom_start pulse", rom_start, 1);
    chk("R8 rom_entry", rom_entry, uops_of(a) & 96'hFFF);
    chk("R7 no miss on complex hit", miss_valid, 0);
    rom_done = 1;  // ignored in the start cycle
    @(negedge clk);
    rom_done = 0;
    chk("R8 start is one cycle, rom_done ignored at start", {rom_start, rsp_valid}, 0);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      chk("R9 stall while rom active", {lk_ready, rsp_valid}, 0);
    end
    rom_done = 1;
    @(negedge clk);
    rom_done = 0;
  endtask

  task automatic lookup_miss(input logic [31:0] a, input bit cplx);
    issue(a);
    @(negedge clk);
    chk("R5 miss_valid", miss_valid, 1);
    chk("R5 miss_addr", miss_addr, a);
    @(negedge clk);
    chk("R5 miss held", {miss_valid, miss_addr}, {1'b1, a});
    chk("R9 lk_ready low in miss", lk_ready, 0);
    miss_ready = 1;
    @(negedge clk);
    miss_ready = 0;
    chk("R6 fill_ready after miss", {fill_ready, miss_valid}, 2'b10);
    @(negedge clk);
    chk("R9 still waiting for fill", {fill_ready, lk_ready}, 2'b10);
    fill_uops = uops_of(a); fill_uop_cnt = ucnt_of(a); fill_insn_cnt = icnt_of(a);
    fill_len = len_of(a); fill_complex = cplx; fill_valid = 1;
    @(negedge clk);
    fill_valid = 0; fill_uops = 0; fill_complex = 0;
    chk("R6 nothing one cycle after fill", {rsp_valid, rom_start, fill_ready}, 0);
    @(negedge clk);
    if (cplx) serve_rom(a);
    take_rsp(a, cplx);
  endtask

  task automatic lookup_hit(input logic [31:0] a, input bit cplx);
    issue(a);
    @(negedge clk);
    chk("R7 hit raises no miss", miss_valid, 0);
    if (cplx) serve_rom(a);
    take_rsp(a, cplx);
  endtask

  task automatic hit_backpressure(input logic [31:0] a);
    issue(a);
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      chk("R4 held rsp_valid", rsp_valid, 1);
      chk("R4 held uops", rsp_uops, uops_of(a));
      chk("R4 held len", rsp_len, len_of(a));
      chk("R9 lk_ready low while rsp waits", lk_ready, 0);
      @(negedge clk);
    end
    take_rsp(a, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {lk_ready, rsp_valid, miss_valid, fill_ready, rom_start}, 5'b10000);
    rst_n = 1;
    chk("R1 idle after reset", {lk_ready, rsp_valid, miss_valid, fill_ready, rom_start}, 5'b10000);
    lookup_miss(32'h0000_1000, 0);      // R1 first lookup misses, R6 fill
    lookup_hit (32'h0000_1000, 0);      // R7
    lookup_miss(32'h0000_1234, 0);
    lookup_hit (32'h0000_1234, 0);
    hit_backpressure(32'h0000_1234);    // R4
    lookup_hit (32'h0000_1000, 0);
    lookup_miss(32'h0000_2000, 0);      // R10 same index as 0x1000
    lookup_miss(32'h0000_1000, 0);      // R10 evicted
    lookup_miss(32'h0000_3058, 1);      // R8 complex fill
    lookup_hit (32'h0000_3058, 1);      // R8 complex hit
    lookup_hit (32'h0000_1000, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule